// File: doc/BRIEF.md
# Prescaled Event Timer with Compare Reset

The block is a free-running up-counter clocked by edges of an external count input. Each input edge passes through a two-stage synchroniser and a rising-edge detector. A prescaler then divides the edges by 1, 2, 4 or 8. Every prescaler output pulse (a "tick") advances the counter by one. A compare register of the same width is loaded through byte-wide bus writes.

A tick that brings the counter to the compare value is a match. A match sets a sticky flag. When the mode field selects the event-reset compare mode, the match also fires a one-cycle trigger and returns the counter to zero. A build-time parameter selects when that reset happens:

- In immediate form, the reset happens on the matching tick itself.
- In deferred form, the counter rests on the compare value and clears on the next tick.

The deferred form therefore gives a period one tick longer for the same compare value.

Software sets the compare value, writes the counter to a starting point, and then uses the trigger pulse to start periodic work. The flag is polled and cleared by software.

Top module: `evt_cmp_timer`

## Requirements
- R1: After a synchronous reset, the counter reads 0, the match flag is 0 and the trigger is 0.
- R2: Each rising edge of the count input advances the prescaler. The prescale select code 0, 1, 2 or 3 makes one counter increment per 1, 2, 4 or 8 edges respectively.
- R3: Bus writes are byte wide. Address bit 1 selects the register (0 = counter, 1 = compare) and address bit 0 selects the byte (0 = low, 1 = high). The counter value is visible on `cntVal`.
- R4: A write to either counter byte, or any change of the prescale select, restarts the prescaler's edge count from zero.
- R5: With mode code 4'b1011 and immediate form, a tick that would bring the counter to the compare value instead loads 0. The trigger is then high for exactly one cycle, so the period is the compare value in ticks.
- R6: With mode code 4'b1011 and deferred form, the counter stops on the compare value. It loads 0, with a one-cycle trigger, on the next tick, so the period is the compare value plus one tick.
- R7: A match sets the match flag. The flag stays set until `flagClr` is asserted. A new match in the same cycle as a clear leaves the flag set.
- R8: With any mode code other than 4'b1011, a match still sets the flag, but the counter keeps counting and the trigger stays low.
- R9: In deferred form, a write to the compare register while a reset is pending cancels it. The next tick then increments the counter instead.
- R10: The counter wraps from 16'hFFFF to 0 on a tick.
- R11: A count input held high for many cycles produces only one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cntIn | input | 1 | External count input, asynchronous |
| psSel | input | 2 | Prescale select: divide by 2^psSel |
| modeSel | input | 4 | Mode code; 4'b1011 enables event reset |
| wrEn | input | 1 | Bus write strobe |
| wrAddr | input | 2 | Bit 1: register select; bit 0: byte select |
| wrData | input | 8 | Bus write byte |
| flagClr | input | 1 | Clears the match flag |
| cntVal | output | 16 | Current counter value |
| matchFlag | output | 1 | Sticky match flag |
| trigOut | output | 1 | One-cycle event trigger |

## Verification
The assertions check the following on every cycle:
- the trigger is never high on two consecutive cycles;
- the trigger appears only in the event mode and leaves the counter at zero unless a write intervened;
- the flag persists until cleared;
- without a write, the counter only holds, steps by one or returns to zero.

The exact cycle of each reset cannot be shown by the assertions; only the directed scenarios show it. Those scenarios establish:
- that the counter resets on the matching tick in immediate form but one tick later in deferred form, including when the prescale is not 1:1;
- that the prescale ratios hold;
- that a compare rewrite cancels a pending reset.

// File: rtl/tce_pkg.sv
package tce_pkg;
  localparam logic [3:0] EVT_MODE = 4'b1011;

  typedef struct packed {
    logic cntInc;
    logic cntZero;
    logic flagSet;
    logic trigFire;
  } ctl_strobe_t;
endpackage

// File: rtl/tce_ctrl.sv
module tce_ctrl
  import tce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PS_W = 2,
  parameter int ADDR_W = 2,
  parameter bit DEFER_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cntIn,
  input  logic [PS_W-1:0]   psSel,
  input  logic [3:0]        modeSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  cmpVal,
  output ctl_strobe_t       strobe
);
  localparam int PSC_W = (1 << PS_W) - 1;

  logic [2:0] syncQ;
  logic [PS_W-1:0] psSelQ;
  logic [PSC_W-1:0] psCnt, psMask;
  logic [PSC_W:0] psOne;
  logic inEdge, psChange, wrCnt, wrCmp, tick, hit, evtMode;
  logic [CNT_W-1:0] nextCnt;

  // two-flop synchroniser plus a third stage for edge detection
  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[1:0], cntIn};
  end
  assign inEdge = syncQ[1] & ~syncQ[2];

  always_ff @(posedge clk) begin
    if (rst) psSelQ <= '0;
    else     psSelQ <= psSel;
  end

  assign psChange = (psSel != psSelQ);
  assign wrCnt    = wrEn && !wrAddr[ADDR_W-1];
  assign wrCmp    = wrEn &&  wrAddr[ADDR_W-1];
  assign evtMode  = (modeSel == EVT_MODE);

  always_comb begin
    psOne  = (PSC_W+1)'(1) << psSel;
    psMask = PSC_W'(psOne - (PSC_W+1)'(1));
  end

  assign tick = inEdge && ((psCnt & psMask) == psMask) && !wrCnt && !psChange;

  always_ff @(posedge clk) begin
    if (rst || wrCnt || psChange) psCnt <= '0;
    else if (tick)                psCnt <= '0;
    else if (inEdge)              psCnt <= psCnt + PSC_W'(1);
  end

  assign nextCnt = cntVal + CNT_W'(1);
  assign hit     = tick && (nextCnt == cmpVal);

  generate
    if (DEFER_RST) begin : g_defer
      logic pend;
      logic fireNow;

      assign fireNow = tick && pend && evtMode && !wrCmp;

      always_ff @(posedge clk) begin
        if (rst || wrCnt || wrCmp || !evtMode) pend <= 1'b0;
        else if (tick && pend)                 pend <= 1'b0;
        else if (hit)                          pend <= 1'b1;
      end

      always_comb begin
        strobe.cntZero  = fireNow;
        strobe.cntInc   = tick && !fireNow;
        strobe.flagSet  = hit;
        strobe.trigFire = fireNow;
      end
    end else begin : g_now
      logic fireNow;

      assign fireNow = hit && evtMode;

      always_comb begin
        strobe.cntZero  = fireNow;
        strobe.cntInc   = tick && !fireNow;
        strobe.flagSet  = hit;
        strobe.trigFire = fireNow;
      end
    end
  endgenerate
endmodule

// File: rtl/tce_dpath.sv
module tce_dpath
  import tce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_strobe_t       strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  output logic [CNT_W-1:0]  cntVal,
  output logic [CNT_W-1:0]  cmpVal,
  output logic              matchFlag,
  output logic              trigOut
);
  localparam int NBYTES = CNT_W / BYTE_W;
  localparam int BIDX_W = ADDR_W - 1;

  logic [NBYTES-1:0] laneCnt, laneCmp;
  logic [CNT_W-1:0] cntNext, cmpNext;

  genvar b;
  generate
    for (b = 0; b < NBYTES; b++) begin : g_lane
      assign laneCnt[b] = wrEn && !wrAddr[ADDR_W-1] && (wrAddr[BIDX_W-1:0] == BIDX_W'(b));
      assign laneCmp[b] = wrEn &&  wrAddr[ADDR_W-1] && (wrAddr[BIDX_W-1:0] == BIDX_W'(b));
    end
  endgenerate

  always_comb begin
    if (strobe.cntZero)     cntNext = '0;
    else if (strobe.cntInc) cntNext = cntVal + CNT_W'(1);
    else                    cntNext = cntVal;
    cmpNext = cmpVal;
    for (int i = 0; i < NBYTES; i++) begin
      if (laneCnt[i]) cntNext[i*BYTE_W +: BYTE_W] = wrData;
      if (laneCmp[i]) cmpNext[i*BYTE_W +: BYTE_W] = wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntVal    <= '0;
      cmpVal    <= '0;
      matchFlag <= 1'b0;
      trigOut   <= 1'b0;
    end else begin
      cntVal    <= cntNext;
      cmpVal    <= cmpNext;
      matchFlag <= strobe.flagSet | (matchFlag & ~flagClr);
      trigOut   <= strobe.trigFire;
    end
  end
endmodule

// File: rtl/evt_cmp_timer.sv
module evt_cmp_timer
  import tce_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BYTE_W = 8,
  parameter int PS_W = 2,
  parameter bit DEFER_RST = 1'b0,
  localparam int NBYTES = CNT_W / BYTE_W,
  localparam int ADDR_W = $clog2(NBYTES) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cntIn,
  input  logic [PS_W-1:0]   psSel,
  input  logic [3:0]        modeSel,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              flagClr,
  output logic [CNT_W-1:0]  cntVal,
  output logic              matchFlag,
  output logic              trigOut
);
  ctl_strobe_t strobe;
  logic [CNT_W-1:0] cmpVal;

  tce_ctrl #(
    .CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DEFER_RST(DEFER_RST)
  ) ctrl_i (
    .clk(clk), .rst(rst), .cntIn(cntIn), .psSel(psSel), .modeSel(modeSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .cntVal(cntVal), .cmpVal(cmpVal),
    .strobe(strobe)
  );

  tce_dpath #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)
  ) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .flagClr(flagClr), .cntVal(cntVal), .cmpVal(cmpVal),
    .matchFlag(matchFlag), .trigOut(trigOut)
  );
endmodule

// File: rtl/evt_cmp_timer_chk.sv
module evt_cmp_timer_chk #(
  parameter int CNT_W = 16,
  parameter int ADDR_W = 2,
  parameter bit DEFER_RST = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        modeSel,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              flagClr,
  input logic [CNT_W-1:0]  cntVal,
  input logic              matchFlag,
  input logic              trigOut
);
  // R5/R6: trigger lasts one cycle
  p_trig_single_r5: assert property (@(posedge clk) disable iff (rst)
    trigOut |=> !trigOut);

  // R8: trigger only after the event mode was selected
  p_trig_mode_r8: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> $past(modeSel) == 4'b1011);

  // R6: trigger leaves counter at zero unless a counter write intervened
  p_trig_zero_r6: assert property (@(posedge clk) disable iff (rst)
    trigOut |-> (cntVal == '0) || $past(wrEn && !wrAddr[ADDR_W-1]));

  // R7: flag sticky until cleared
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (matchFlag && !flagClr) |=> matchFlag);

  // R2/R10: without writes the counter only holds, steps or clears
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> (cntVal == $past(cntVal)) || (cntVal == $past(cntVal) + 1'b1)
              || (cntVal == '0));

  generate
    if (!DEFER_RST) begin : g_now_chk
      // R5: in immediate form the flag rises together with the trigger
      p_trig_flag_r5: assert property (@(posedge clk) disable iff (rst)
        trigOut |-> matchFlag);
    end
  endgenerate
endmodule

bind evt_cmp_timer evt_cmp_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DEFER_RST(DEFER_RST)
) chk_i (
  .clk(clk), .rst(rst), .modeSel(modeSel), .wrEn(wrEn), .wrAddr(wrAddr),
  .flagClr(flagClr), .cntVal(cntVal), .matchFlag(matchFlag), .trigOut(trigOut)
);

// File: tb/evt_cmp_timer_tb_top.sv
module evt_cmp_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cntIn = 1'b0;
  logic [1:0] psSel = '0;
  logic [3:0] modeSel = '0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic flagClr = 1'b0;
  logic [15:0] cntI, cntD;
  logic flagI, flagD, trigI, trigD;
  int total = 0;
  int bad = 0;
  int trigCntI = 0;
  int trigCntD = 0;

  always #10 clk = ~clk;

  evt_cmp_timer #(.DEFER_RST(1'b0)) dut_i (
    .clk(clk), .rst(rst), .cntIn(cntIn), .psSel(psSel), .modeSel(modeSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .flagClr(flagClr),
    .cntVal(cntI), .matchFlag(flagI), .trigOut(trigI));

  evt_cmp_timer #(.DEFER_RST(1'b1)) dut_d (
    .clk(clk), .rst(rst), .cntIn(cntIn), .psSel(psSel), .modeSel(modeSel),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .flagClr(flagClr),
    .cntVal(cntD), .matchFlag(flagD), .trigOut(trigD));

  always @(negedge clk) begin
    if (!rst && trigI) trigCntI++;
    if (!rst && trigD) trigCntD++;
  end

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wr16(input logic isCmp, input logic [15:0] v);
    wrReg({isCmp, 1'b0}, v[7:0]);
    wrReg({isCmp, 1'b1}, v[15:8]);
  endtask

  task automatic pulse(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cntIn = 1'b1;
      repeat (3) @(negedge clk);
      cntIn = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic clearFlag();
    @(negedge clk); flagClr = 1'b1;
    @(negedge clk); flagClr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 cnt", cntI, 0);
    check("R1 flag", flagI, 0);
    check("R1 trig", trigI, 0);
  endtask

  task automatic t_prescale();
    modeSel = 4'd0; wr16(1'b1, 16'h0000);
    psSel = 2'd0; wr16(1'b0, 16'h0000);
    pulse(5);  check("R2 div1", cntI, 5);
    psSel = 2'd1; wr16(1'b0, 16'h0000);
    pulse(4);  check("R2 div2", cntI, 2);
    psSel = 2'd2; wr16(1'b0, 16'h0000);
    pulse(8);  check("R2 div4", cntI, 2);
    psSel = 2'd3; wr16(1'b0, 16'h0000);
    pulse(8);  check("R2 div8", cntI, 1);
  endtask

  task automatic t_bytes();
    wr16(1'b0, 16'h1234);
    check("R3 word", cntI, 16'h1234);
    wrReg(2'b00, 8'hA5);
    check("R3 low byte", cntI, 16'h12A5);
  endtask

  task automatic t_psclear();
    psSel = 2'd2; wr16(1'b0, 16'h0000);
    pulse(3);
    wr16(1'b0, 16'h0000);
    pulse(1);  check("R4 write restarts", cntI, 0);
    pulse(3);  check("R4 after restart", cntI, 1);
    pulse(3);
    psSel = 2'd1;
    pulse(1);  check("R4 select change restarts", cntI, 1);
    pulse(1);  check("R4 after select change", cntI, 2);
  endtask

  task automatic t_event();
    int ti, td;
    psSel = 2'd0; modeSel = 4'b1011;
    wr16(1'b1, 16'd5); wr16(1'b0, 16'd0); clearFlag();
    ti = trigCntI; td = trigCntD;
    pulse(4);
    check("R5 before match", cntI, 4);
    pulse(1);
    check("R5 immediate reset", cntI, 0);
    check("R5 one trigger", trigCntI - ti, 1);
    check("R7 flag set", flagI, 1);
    check("R6 holds on compare", cntD, 5);
    check("R6 no trigger yet", trigCntD - td, 0);
    pulse(1);
    check("R6 deferred reset", cntD, 0);
    check("R6 one trigger", trigCntD - td, 1);
    pulse(10);
    check("R5 period", trigCntI - ti, 3);
    check("R6 period", trigCntD - td, 2);
  endtask

  task automatic t_event_ps2();
    int td;
    psSel = 2'd1; modeSel = 4'b1011;
    wr16(1'b1, 16'd3); wr16(1'b0, 16'd0);
    td = trigCntD;
    pulse(6);
    check("R5 immediate with prescale", cntI, 0);
    check("R6 at compare with prescale", cntD, 3);
    pulse(1);
    check("R6 waits for prescaler", cntD, 3);
    pulse(1);
    check("R6 reset on next tick", cntD, 0);
    check("R6 trigger with prescale", trigCntD - td, 1);
  endtask

  task automatic t_flag();
    clearFlag();
    check("R7 cleared", flagI, 0);
    @(negedge clk);
    check("R7 stays clear", flagI, 0);
  endtask

  task automatic t_other_mode();
    int ti;
    psSel = 2'd0; modeSel = 4'd0;
    wr16(1'b1, 16'd3); wr16(1'b0, 16'd0); clearFlag();
    ti = trigCntI;
    pulse(4);
    check("R8 keeps counting", cntI, 4);
    check("R8 flag set", flagI, 1);
    check("R8 no trigger", trigCntI - ti, 0);
  endtask

  task automatic t_cancel();
    int td;
    psSel = 2'd0; modeSel = 4'b1011;
    wr16(1'b1, 16'd5); wr16(1'b0, 16'd0);
    td = trigCntD;
    pulse(5);
    check("R9 pending", cntD, 5);
    wr16(1'b1, 16'd9);
    pulse(1);
    check("R9 cancelled", cntD, 6);
    check("R9 no trigger", trigCntD - td, 0);
    pulse(4);
    check("R9 new compare", cntD, 0);
  endtask

  task automatic t_wrap();
    psSel = 2'd0; modeSel = 4'd0;
    wr16(1'b1, 16'h0100); wr16(1'b0, 16'hFFFF);
    pulse(1);
    check("R10 wrap", cntI, 0);
  endtask

  task automatic t_hold();
    psSel = 2'd0; modeSel = 4'd0;
    wr16(1'b0, 16'd0);
    @(negedge clk); cntIn = 1'b1;
    repeat (12) @(negedge clk);
    check("R11 held high counts once", cntI, 1);
    cntIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_prescale();
    t_bytes();
    t_psclear();
    t_event();
    t_event_ps2();
    t_flag();
    t_other_mode();
    t_cancel();
    t_wrap();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule